// File: doc/BRIEF.md
# Store-String Byte Sequencer

This block carries out one store-string-word-immediate instruction over several cycles. It is handed a 32-bit instruction word with a start pulse. If the word carries the right opcode pair, the block reads the base register through a shared register-file read port. A base field of zero stands for an address of zero. The block then walks successive source registers and emits their bytes one at a time on a byte-wide memory write port.

The byte count comes from a 5-bit immediate. Within each source register the most significant byte goes first. The final register may be used only in part. Source register numbers wrap from 31 back to 0. When reservation tracking is on and some agent holds a reservation, one or two line-invalidate pulses go out before the first byte. The first covers the line holding the first byte. The second covers the line holding the last byte, and is sent only when that line differs from the first. A one-cycle done pulse, paired with a program-counter advance strobe, closes the operation.

Top module: `strstore_seq`

## Requirements
- R1: A start pulse is accepted only when insn[31:26] (big-endian bits 0–5) equals 31 and insn[10:1] (bits 21–30) equals 725. Insn[0] is a don't-care. Any other word leaves busy low and produces no memory write.
- R2: The first source register is insn[25:21], the base register is insn[20:16] and the count field is insn[15:11]. The first byte is written at the base register's value and comes from the first source register.
- R3: A count field of 0 moves 32 bytes. A value n from 1 to 31 moves exactly n bytes, so exactly that many writes are accepted.
- R4: A base field of 0 gives a start address of 0, whatever register 0 holds. Otherwise the start address is the register's low 32 bits.
- R5: Each register gives up its bytes from bits 31:24 down to bits 7:0, written to addresses that rise by one per byte.
- R6: After four bytes of a register have been used, the next register number is the current one plus one, modulo 32, so register 31 is followed by register 0.
- R7: When the count is not a multiple of 4, only the leading bytes of the last register are written.
- R8: The write address wraps from 0xFFFFFFFF to 0x00000000.
- R9: A line is an address with its low log2(LINE_BYTES) bits cleared. If both rsv_track_en and rsv_active are high when the base is read, inv_valid pulses once with the first byte's line, then once more with the last byte's line if it differs. Otherwise no invalidate is sent. Every invalidate comes before the first write.
- R10: While mem_we is high and mem_ready is low, mem_we, mem_addr and mem_wdata hold their values.
- R11: After reset, busy, done, pc_adv4, mem_we and inv_valid are low. Busy rises in the cycle after an accepted start. Done and pc_adv4 are high together for exactly one cycle, the cycle after the final byte is accepted.
- R12: A start pulse that arrives while busy is high has no effect, and no further writes follow the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, sampled with insn |
| insn | input | 32 | Instruction word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_adv4 | output | 1 | Program counter advance-by-4 strobe |
| rf_raddr | output | 5 | Register-file read address |
| rf_rdata | input | 32 | Register-file read data, same cycle |
| rsv_track_en | input | 1 | Reservation tracking enabled |
| rsv_active | input | 1 | At least one reservation is held |
| inv_valid | output | 1 | Line-invalidate request |
| inv_line | output | 32 | Line address to invalidate |
| mem_we | output | 1 | Byte write request |
| mem_addr | output | 32 | Byte write address |
| mem_wdata | output | 8 | Byte write data |
| mem_ready | input | 1 | Memory accepts the write this cycle |

## Verification
A vector table drives operations whose counts are 4, 5, 7, 9, 31 and 32. Between them these cover a whole-register transfer, partial final registers and the zero-means-32 case. Source starts at registers 30 and 31 separate a correct modulo-32 wrap from a run off the end of the file. A base of zero whose register 0 holds a nonzero value separates literal zero from a read of the register. A base near the top of the address space exposes a missing address wrap. Base and count pairs that stay in one line, cross a line, or run with tracking off or no reservers tell zero, one and two invalidates apart. A mode in which the memory is ready only one cycle in three shows whether writes are held stably.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BASE,
    S_INV_FIRST,
    S_INV_LAST,
    S_XFER,
    S_DONE
  } ssq_state_e;

  localparam logic [5:0] PRIMARY_OP = 6'd31;
  localparam logic [9:0] EXT_OP     = 10'd725;

  // Count field to byte total: zero encodes a full 32-byte transfer.
  function automatic logic [5:0] byte_total(input logic [4:0] field);
    return (field == 5'd0) ? 6'd32 : {1'b0, field};
  endfunction

  // Byte lane selection, most significant lane first.
  function automatic logic [7:0] lane_byte(input logic [31:0] word, input logic [1:0] lane);
    logic [7:0] b;
    case (lane)
      2'd0:    b = word[31:24];
      2'd1:    b = word[23:16];
      2'd2:    b = word[15:8];
      default: b = word[7:0];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/ssq_decode.sv
module ssq_decode
  import ssq_pkg::*;
(
  input  logic [31:0] insn,
  output logic        hit,
  output logic [4:0]  src_reg,
  output logic [4:0]  base_reg,
  output logic [5:0]  total
);
  logic rc_unused;

  assign hit       = (insn[31:26] == PRIMARY_OP) && (insn[10:1] == EXT_OP);
  assign src_reg   = insn[25:21];
  assign base_reg  = insn[20:16];
  assign total     = byte_total(insn[15:11]);
  assign rc_unused = insn[0];

  always_comb begin
    if (hit) begin
      AST_TOTAL_RANGE: assert (total != 6'd0 && total <= 6'd32); // R3
    end
  end
endmodule

// File: rtl/ssq_lines.sv
module ssq_lines #(
  parameter int LINE_BYTES = 128
) (
  input  logic [31:0] ea,
  input  logic [5:0]  total,
  output logic [31:0] first_line,
  output logic [31:0] last_line,
  output logic        split
);
  localparam int          LINE_LSB  = $clog2(LINE_BYTES);
  localparam logic [31:0] LINE_MASK = ~((32'd1 << LINE_LSB) - 32'd1);

  logic [31:0] last_byte;

  assign last_byte  = ea + {26'd0, total} - 32'd1;
  assign first_line = ea & LINE_MASK;
  assign last_line  = last_byte & LINE_MASK;
  assign split      = (first_line != last_line);
endmodule

// File: rtl/strstore_seq.sv
module strstore_seq
  import ssq_pkg::*;
#(
  parameter int LINE_BYTES = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] insn,
  output logic        busy,
  output logic        done,
  output logic        pc_adv4,
  output logic [4:0]  rf_raddr,
  input  logic [31:0] rf_rdata,
  input  logic        rsv_track_en,
  input  logic        rsv_active,
  output logic        inv_valid,
  output logic [31:0] inv_line,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_ready
);
  localparam int          LINE_LSB  = $clog2(LINE_BYTES);
  localparam logic [31:0] LOW_MASK  = (32'd1 << LINE_LSB) - 32'd1;

  ssq_state_e  state;
  logic [4:0]  rs_q, ra_q;
  logic [5:0]  left_q;
  logic [1:0]  lane_q;
  logic [31:0] ea_q, first_q, last_q;
  logic        split_q;

  logic        dec_hit;
  logic [4:0]  dec_rs, dec_ra;
  logic [5:0]  dec_total;
  logic [31:0] base_ea, ln_first, ln_last;
  logic        ln_split;

  // Named internal events
  logic accept_start, byte_accept, last_accept, want_inv;

  ssq_decode u_dec (
    .insn     (insn),
    .hit      (dec_hit),
    .src_reg  (dec_rs),
    .base_reg (dec_ra),
    .total    (dec_total)
  );

  assign base_ea = (ra_q == 5'd0) ? 32'd0 : rf_rdata;

  ssq_lines #(.LINE_BYTES(LINE_BYTES)) u_lines (
    .ea         (base_ea),
    .total      (left_q),
    .first_line (ln_first),
    .last_line  (ln_last),
    .split      (ln_split)
  );

  assign accept_start = (state == S_IDLE) && start && dec_hit;
  assign byte_accept  = mem_we && mem_ready;
  assign last_accept  = byte_accept && (left_q == 6'd1);
  assign want_inv     = rsv_track_en && rsv_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      rs_q    <= '0;
      ra_q    <= '0;
      left_q  <= '0;
      lane_q  <= '0;
      ea_q    <= '0;
      first_q <= '0;
      last_q  <= '0;
      split_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept_start) begin
            rs_q   <= dec_rs;
            ra_q   <= dec_ra;
            left_q <= dec_total;
            lane_q <= 2'd0;
            state  <= S_BASE;
          end
        end
        S_BASE: begin
          ea_q    <= base_ea;
          first_q <= ln_first;
          last_q  <= ln_last;
          split_q <= ln_split;
          state   <= want_inv ? S_INV_FIRST : S_XFER;
        end
        S_INV_FIRST: state <= split_q ? S_INV_LAST : S_XFER;
        S_INV_LAST:  state <= S_XFER;
        S_XFER: begin
          if (byte_accept) begin
            ea_q   <= ea_q + 32'd1;
            left_q <= left_q - 6'd1;
            lane_q <= lane_q + 2'd1;
            if (lane_q == 2'd3) rs_q <= rs_q + 5'd1;
            if (last_accept) state <= S_DONE;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign pc_adv4   = (state == S_DONE);
  assign rf_raddr  = (state == S_BASE) ? ra_q : rs_q;
  assign inv_valid = (state == S_INV_FIRST) || (state == S_INV_LAST);
  assign inv_line  = (state == S_INV_LAST) ? last_q : first_q;
  assign mem_we    = (state == S_XFER);
  assign mem_addr  = ea_q;
  assign mem_wdata = lane_byte(rf_rdata, lane_q);

  AST_LAUNCH_DECODED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start && insn[31:26] == 6'd31 && insn[10:1] == 10'd725)); // R1

  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_ready) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata))); // R10

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_accept |=> (!mem_we || mem_addr == $past(mem_addr) + 32'd1)); // R8

  AST_INV_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> ((inv_line & LOW_MASK) == 32'd0)); // R9

  AST_INV_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !done); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_we && mem_ready)); // R11

  AST_STAY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R12
endmodule

// File: tb/tb_strstore_seq.sv
module tb_strstore_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] insn = '0;
  logic        busy, done, pc_adv4, inv_valid, mem_we;
  logic [4:0]  rf_raddr;
  logic [31:0] rf_rdata, inv_line, mem_addr;
  logic [7:0]  mem_wdata;
  logic        rsv_track_en = 1'b0, rsv_active = 1'b0;
  logic        mem_ready;

  always #10 clk = ~clk;  // 50 MHz

  logic [31:0] regs [32];
  assign rf_rdata = regs[rf_raddr];

  strstore_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
    .busy(busy), .done(done), .pc_adv4(pc_adv4),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rsv_track_en(rsv_track_en), .rsv_active(rsv_active),
    .inv_valid(inv_valid), .inv_line(inv_line),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  logic stall_mode = 1'b0;
  logic [31:0] wr_addr [64];
  logic [7:0]  wr_data [64];
  int wr_n = 0;
  logic [31:0] inv_log [4];
  int inv_n = 0, done_n = 0, pc_n = 0, pc_bad = 0, late_inv = 0;
  int last_wr_cyc = 0, done_cyc = 0;
  logic finished = 1'b0;

  // Monitor and memory model, all on the falling edge.
  always @(negedge clk) begin
    cyc = cyc + 1;
    mem_ready = !stall_mode || (cyc % 3 == 0);
    if (mem_we && mem_ready) begin
      if (wr_n < 64) begin
        wr_addr[wr_n] = mem_addr;
        wr_data[wr_n] = mem_wdata;
      end
      wr_n = wr_n + 1;
      last_wr_cyc = cyc;
    end
    if (inv_valid) begin
      if (inv_n < 4) inv_log[inv_n] = inv_line;
      inv_n = inv_n + 1;
      if (wr_n > 0) late_inv = late_inv + 1;
    end
    if (done) begin
      done_n = done_n + 1;
      done_cyc = cyc;
    end
    if (pc_adv4) pc_n = pc_n + 1;
    if (pc_adv4 != done) pc_bad = pc_bad + 1;
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] mk_insn(input logic [4:0] rs, input logic [4:0] ra,
                                          input logic [4:0] nb, input logic rc);
    return {6'd31, rs, ra, nb, 10'd725, rc};
  endfunction

  task automatic clear_logs();
    wr_n = 0; inv_n = 0; done_n = 0; pc_n = 0; late_inv = 0;
  endtask

  task automatic run_op(input logic [4:0] rs, input logic [4:0] ra, input logic [4:0] nb,
                        input logic [31:0] base, input logic trk, input logic act,
                        input logic stl, input logic rc);
    int n;
    logic [31:0] ea, fl, ll;
    int exp_inv;
    if (ra != 5'd0) regs[ra] = base;
    @(negedge clk);
    clear_logs();
    stall_mode   = stl;
    rsv_track_en = trk;
    rsv_active   = act;
    insn  = mk_insn(rs, ra, nb, rc);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    for (int g = 0; g < 400 && done_n == 0; g++) @(negedge clk);
    @(negedge clk);

    n  = (nb == 5'd0) ? 32 : int'(nb);
    ea = (ra == 5'd0) ? 32'd0 : base;
    chk(wr_n == n, "R3 byte count", wr_n, n);
    if (wr_n > 0) begin
      chk(wr_addr[0] == ea, "R2/R4 first address", wr_addr[0], ea);
      chk(wr_data[0] == regs[rs][31:24], "R2 first byte", wr_data[0], regs[rs][31:24]);
    end
    for (int k = 0; k < n && k < wr_n; k++) begin
      logic [4:0]  r;
      logic [7:0]  eb;
      logic [31:0] wa;
      r  = 5'((int'(rs) + k / 4) % 32);
      eb = 8'(regs[r] >> (24 - 8 * (k % 4)));
      wa = ea + 32'(k);
      chk(wr_addr[k] == wa, "R5/R8 address", wr_addr[k], wa);
      chk(wr_data[k] == eb, "R5/R6/R7 data", wr_data[k], eb);
    end
    fl = ea & ~32'd127;
    ll = (ea + 32'(n) - 32'd1) & ~32'd127;
    exp_inv = (trk && act) ? ((fl != ll) ? 2 : 1) : 0;
    chk(inv_n == exp_inv, "R9 invalidate count", inv_n, exp_inv);
    if (exp_inv >= 1 && inv_n >= 1) chk(inv_log[0] == fl, "R9 first line", inv_log[0], fl);
    if (exp_inv == 2 && inv_n >= 2) chk(inv_log[1] == ll, "R9 last line", inv_log[1], ll);
    chk(late_inv == 0, "R9 invalidate after write", late_inv, 0);
    chk(done_n == 1 && pc_n == 1, "R11 done and pc pulse count", done_n * 16 + pc_n, 17);
    chk(done_cyc == last_wr_cyc + 1, "R11 done timing", done_cyc, last_wr_cyc + 1);
    chk(busy == 1'b0, "R11 idle after done", busy, 0);
  endtask

  typedef struct packed {
    logic [4:0]  rs;
    logic [4:0]  ra;
    logic [4:0]  nb;
    logic [31:0] base;
    logic        trk;
    logic        act;
    logic        stl;
    logic        rc;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{rs:5'd3,  ra:5'd5, nb:5'd7,  base:32'h0000_1000, trk:1'b1, act:1'b1, stl:1'b0, rc:1'b0},
    '{rs:5'd30, ra:5'd0, nb:5'd0,  base:32'h0000_0000, trk:1'b1, act:1'b1, stl:1'b0, rc:1'b1},
    '{rs:5'd10, ra:5'd2, nb:5'd9,  base:32'h0000_007E, trk:1'b1, act:1'b1, stl:1'b0, rc:1'b0},
    '{rs:5'd1,  ra:5'd4, nb:5'd4,  base:32'hFFFF_FFFE, trk:1'b1, act:1'b0, stl:1'b0, rc:1'b0},
    '{rs:5'd31, ra:5'd6, nb:5'd5,  base:32'h0000_2003, trk:1'b0, act:1'b1, stl:1'b1, rc:1'b0},
    '{rs:5'd8,  ra:5'd7, nb:5'd31, base:32'h0000_0040, trk:1'b1, act:1'b1, stl:1'b1, rc:1'b0}
  };

  initial begin
    mem_ready = 1'b1;
    for (int i = 0; i < 32; i++)
      regs[i] = {8'(i + 8'h10), 8'(i ^ 8'hA5), 8'(~i), 8'(i + 8'h3C)};
    regs[0] = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && pc_adv4 == 0 && mem_we == 0 && inv_valid == 0,
        "R11 reset outputs", {busy, done, pc_adv4, mem_we, inv_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R11 idle after reset", busy, 0);

    for (int v = 0; v < NV; v++)
      run_op(VECS[v].rs, VECS[v].ra, VECS[v].nb, VECS[v].base,
             VECS[v].trk, VECS[v].act, VECS[v].stl, VECS[v].rc);

    // R1: wrong extended opcode is ignored
    @(negedge clk);
    clear_logs();
    stall_mode = 1'b0;
    insn  = {6'd31, 5'd1, 5'd2, 5'd4, 10'd724, 1'b0};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 0, "R1 bad extended opcode busy", busy, 0);
    insn  = {6'd30, 5'd1, 5'd2, 5'd4, 10'd725, 1'b0};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 0, "R1 bad primary opcode busy", busy, 0);
    repeat (5) @(negedge clk);
    chk(wr_n == 0 && done_n == 0, "R1 no writes for bad opcode", wr_n, 0);

    // R12: start while busy is ignored
    regs[9] = 32'h0000_0300;
    @(negedge clk);
    clear_logs();
    stall_mode = 1'b1;
    rsv_track_en = 1'b0;
    insn  = mk_insn(5'd12, 5'd9, 5'd8, 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    insn  = mk_insn(5'd20, 5'd0, 5'd2, 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int g = 0; g < 400 && done_n == 0; g++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(wr_n == 8, "R12 writes of running op only", wr_n, 8);
    chk(wr_addr[0] == 32'h300, "R12 first address kept", wr_addr[0], 32'h300);
    chk(wr_addr[7] == 32'h307, "R12 last address kept", wr_addr[7], 32'h307);
    chk(done_n == 1 && busy == 0, "R12 single completion", done_n, 1);
    chk(pc_bad == 0, "R11 pc strobe matches done", pc_bad, 0);

    finish_up();
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    finish_up();
  end
endmodule